// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept or discarded by looking only at its 48-bit destination address. Individual (unicast) addresses are compared against a small table of exact-match entries. Group (multicast) addresses are reduced to a hash bin, and the bin is looked up in a bit table that software loads. A set of mode bits can widen acceptance: all frames, all group frames, or every frame for debug. Broadcast can be switched off separately.

The address arrives as one 48-bit word with a one-cycle valid strobe. The first byte on the wire is `destAddr[7:0]`, and within each byte the bits are taken least significant first. Three register-style write ports load the exact-match entries, the 32-bit hash words and the mode bits. Each lookup produces a one-cycle decision pulse two cycles after its strobe. The pulse carries the accept bit and flags that say whether the exact table or the hash table matched. Lookups may be issued on back-to-back cycles.

Top module: `rxAddrFilter`

## Requirements
- R1: `decValid` pulses high for exactly one cycle, two clock edges after each cycle in which `daValid` is sampled high. Back-to-back strobes give back-to-back pulses. `accept`, `perfectHit` and `hashHit` are 0 whenever `decValid` is 0.
- R2: The hash bin index is computed with the reflected CRC-32 (polynomial 0xEDB88320, preset all ones) run over the 48 address bits in wire order. The result is complemented and bit-reversed, and the top HASH_BITS bits of that value are the index (HASH_BITS = 6, 7 or 8).
- R3: Index bits HASH_BITS-1..5 select one of 2^(HASH_BITS-5) hash words, and index bits 4..0 select the bit inside that word. When mode bit 2 (hash multicast) is set, a non-broadcast group frame is accepted exactly when that bit is 1.
- R4: When mode bit 0 (promiscuous) is set, every frame is accepted.
- R5: When mode bit 1 (all multicast) is set, every group frame is accepted whatever the hash table holds.
- R6: When mode bit 3 (receive all) is set, every frame is accepted.
- R7: The all-ones broadcast address is accepted unless mode bit 4 (broadcast disable) is set. Broadcast never sets `hashHit`, and R4/R6 still accept it.
- R8: An individual address is accepted when it equals the address of an entry whose enable bit is set. A disabled entry never matches. Entry 0 holds the station address.
- R9: A frame is a group frame when `destAddr[0]` is 1. Without R4-R6, a group frame that is not broadcast and not passed by R3 is dropped, and an individual address that matches no enabled entry is dropped.
- R10: `perfectHit` is 1 for an individual address that matches an enabled entry. `hashHit` is 1 when R3 accepts a group frame through its bin bit. The two flags are never high together, and either one implies `accept`.
- R11: After reset, all outputs are 0, all mode bits are 0, every entry is disabled and every hash word is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| daValid | input | 1 | Destination address strobe |
| destAddr | input | 48 | Destination address, first wire byte in [7:0] |
| entWrEn | input | 1 | Write strobe for an exact-match entry |
| entWrSel | input | ENT_W | Entry index to write |
| entWrAddr | input | 48 | Address stored in the entry |
| entWrOn | input | 1 | Enable bit stored with the entry |
| hashWrEn | input | 1 | Write strobe for a hash word |
| hashWrSel | input | WORD_W | Hash word index |
| hashWrData | input | 32 | Hash word value |
| modeWrEn | input | 1 | Write strobe for the mode bits |
| modeWrData | input | 5 | Mode: 0 promiscuous, 1 all multicast, 2 hash multicast, 3 receive all, 4 broadcast disable |
| decValid | output | 1 | Decision valid pulse |
| accept | output | 1 | Frame accepted |
| perfectHit | output | 1 | Exact-match table hit |
| hashHit | output | 1 | Hash bin hit |

## Verification
Each decision is due at the negative edge that follows the second rising edge after its strobe was driven. The driver pushes the expected accept bit and flags into a queue, together with the edge count at which they are due. The monitor pops an item only when `decValid` is high and compares both the values and the edge count, so an early, late or missing pulse shows up as a miscompare. Table and mode writes are modelled when they are issued. Because a write commits one edge later, each expected value reflects exactly the table state the design reads.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  typedef struct packed {
    logic bcastDis;
    logic rxAll;
    logic hashMc;
    logic passMc;
    logic promisc;
  } modeT;

  typedef struct packed {
    logic capture;
    logic decide;
  } strobeT;

  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
endpackage

// File: rtl/rxafCtrl.sv
module rxafCtrl
  import rxaf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       daValid,
  input  logic       modeWrEn,
  input  logic [4:0] modeWrData,
  output strobeT     strobes,
  output modeT       mode,
  output logic       decValid
);
  logic v1, v2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1   <= 1'b0;
      v2   <= 1'b0;
      mode <= '0;
    end else begin
      v1 <= daValid;
      v2 <= v1;
      if (modeWrEn) mode <= modeT'(modeWrData);
    end
  end

  assign strobes.capture = daValid;
  assign strobes.decide  = v1;
  assign decValid        = v2;
endmodule

// File: rtl/rxafDatapath.sv
module rxafDatapath
  import rxaf_pkg::*;
#(
  parameter int HASH_BITS   = 6,
  parameter int NUM_ENTRIES = 4,
  localparam int ENT_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int WORD_W     = HASH_BITS - 5,
  localparam int NUM_WORDS  = 1 << WORD_W
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  modeT              mode,
  input  logic [47:0]       destAddr,
  input  logic              entWrEn,
  input  logic [ENT_W-1:0]  entWrSel,
  input  logic [47:0]       entWrAddr,
  input  logic              entWrOn,
  input  logic              hashWrEn,
  input  logic [WORD_W-1:0] hashWrSel,
  input  logic [31:0]       hashWrData,
  output logic              accept,
  output logic              perfectHit,
  output logic              hashHit
);
  logic [47:0]            entAddr [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] entOn;
  logic [31:0]            hashWords [NUM_WORDS];

  // table storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      entOn <= '0;
      for (int i = 0; i < NUM_ENTRIES; i++) entAddr[i] <= '0;
      for (int i = 0; i < NUM_WORDS; i++) hashWords[i] <= '0;
    end else begin
      if (entWrEn && (int'(entWrSel) < NUM_ENTRIES)) begin
        entAddr[entWrSel] <= entWrAddr;
        entOn[entWrSel]   <= entWrOn;
      end
      if (hashWrEn) hashWords[hashWrSel] <= hashWrData;
    end
  end

  // CRC over the address bits in wire order
  function automatic logic [31:0] crcOf(input logic [47:0] a);
    logic [31:0] c;
    logic fb;
    c = '1;
    for (int i = 0; i < 48; i++) begin
      fb = c[0] ^ a[i];
      c  = {1'b0, c[31:1]} ^ (fb ? CRC_POLY : 32'h0);
    end
    return c;
  endfunction

  logic [31:0]          crcVal;
  logic [HASH_BITS-1:0] binIdx;
  always_comb begin
    crcVal = crcOf(destAddr);
    for (int j = 0; j < HASH_BITS; j++) binIdx[HASH_BITS-1-j] = ~crcVal[j];
  end

  // exact compare, one comparator per entry
  logic [NUM_ENTRIES-1:0] matchVec;
  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_cmp
    assign matchVec[e] = entOn[e] && (entAddr[e] == destAddr);
  end

  // stage 1: capture lookup results
  logic [HASH_BITS-1:0] s1Idx;
  logic s1Group, s1Bcast, s1Perf;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Idx   <= '0;
      s1Group <= 1'b0;
      s1Bcast <= 1'b0;
      s1Perf  <= 1'b0;
    end else if (strobes.capture) begin
      s1Idx   <= binIdx;
      s1Group <= destAddr[0];
      s1Bcast <= &destAddr;
      s1Perf  <= !destAddr[0] && (|matchVec);
    end
  end

  // stage 2: bin read and mode resolution
  logic [31:0] selWord;
  logic binSet, hashOk, accNext;
  always_comb begin
    selWord = hashWords[s1Idx[HASH_BITS-1:5]];
    binSet  = selWord[s1Idx[4:0]];
    hashOk  = s1Group && !s1Bcast && mode.hashMc && binSet;
    if (mode.rxAll || mode.promisc) accNext = 1'b1;
    else if (s1Bcast)               accNext = !mode.bcastDis;
    else if (s1Group)               accNext = mode.passMc || hashOk;
    else                            accNext = s1Perf;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accept     <= 1'b0;
      perfectHit <= 1'b0;
      hashHit    <= 1'b0;
    end else begin
      accept     <= strobes.decide && accNext;
      perfectHit <= strobes.decide && s1Perf;
      hashHit    <= strobes.decide && hashOk;
    end
  end
endmodule

// File: rtl/rxAddrFilter.sv
module rxAddrFilter
  import rxaf_pkg::*;
#(
  parameter int HASH_BITS   = 6,
  parameter int NUM_ENTRIES = 4,
  localparam int ENT_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int WORD_W     = HASH_BITS - 5
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              daValid,
  input  logic [47:0]       destAddr,
  input  logic              entWrEn,
  input  logic [ENT_W-1:0]  entWrSel,
  input  logic [47:0]       entWrAddr,
  input  logic              entWrOn,
  input  logic              hashWrEn,
  input  logic [WORD_W-1:0] hashWrSel,
  input  logic [31:0]       hashWrData,
  input  logic              modeWrEn,
  input  logic [4:0]        modeWrData,
  output logic              decValid,
  output logic              accept,
  output logic              perfectHit,
  output logic              hashHit
);
  strobeT strobes;
  modeT   mode;

  rxafCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .daValid    (daValid),
    .modeWrEn   (modeWrEn),
    .modeWrData (modeWrData),
    .strobes    (strobes),
    .mode       (mode),
    .decValid   (decValid)
  );

  rxafDatapath #(.HASH_BITS(HASH_BITS), .NUM_ENTRIES(NUM_ENTRIES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .mode       (mode),
    .destAddr   (destAddr),
    .entWrEn    (entWrEn),
    .entWrSel   (entWrSel),
    .entWrAddr  (entWrAddr),
    .entWrOn    (entWrOn),
    .hashWrEn   (hashWrEn),
    .hashWrSel  (hashWrSel),
    .hashWrData (hashWrData),
    .accept     (accept),
    .perfectHit (perfectHit),
    .hashHit    (hashHit)
  );
endmodule

// File: rtl/rxafChecker.sv
module rxafChecker (
  input logic       clk,
  input logic       rstN,
  input logic       daValid,
  input logic       modeWrEn,
  input logic [4:0] modeWrData,
  input logic       decValid,
  input logic       accept,
  input logic       perfectHit,
  input logic       hashHit
);
  logic [4:0] shMode;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shMode <= '0;
    else if (modeWrEn) shMode <= modeWrData;
  end

  AST_DUE_PULSE: assert property (@(posedge clk) disable iff (!rstN) daValid |=> ##1 decValid); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rstN) decValid |-> $past(daValid, 2)); // R1
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN) !decValid |-> !(accept || perfectHit || hashHit)); // R1
  AST_PROMISC_ALL: assert property (@(posedge clk) disable iff (!rstN) (decValid && $past(shMode[0])) |-> accept); // R4
  AST_RXALL_ALL: assert property (@(posedge clk) disable iff (!rstN) (decValid && $past(shMode[3])) |-> accept); // R6
  AST_HIT_EXCL: assert property (@(posedge clk) disable iff (!rstN) !(perfectHit && hashHit)); // R10
  AST_HIT_ACCEPT: assert property (@(posedge clk) disable iff (!rstN) (perfectHit || hashHit) |-> accept); // R10
endmodule

bind rxAddrFilter rxafChecker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .daValid    (daValid),
  .modeWrEn   (modeWrEn),
  .modeWrData (modeWrData),
  .decValid   (decValid),
  .accept     (accept),
  .perfectHit (perfectHit),
  .hashHit    (hashHit)
);

// File: tb/tb_rxAddrFilter.sv
module tb_rxAddrFilter;
  localparam int PERIOD = 10;
  localparam int HB = 6;
  localparam int NE = 4;
  localparam int EW = 2;
  localparam int WW = HB - 5;
  localparam int NW = 1 << WW;

  logic clk = 0, rstN = 0, daValid = 0;
  logic [47:0] destAddr = '0;
  logic entWrEn = 0, entWrOn = 0, hashWrEn = 0, modeWrEn = 0;
  logic [EW-1:0] entWrSel = '0;
  logic [47:0] entWrAddr = '0;
  logic [WW-1:0] hashWrSel = '0;
  logic [31:0] hashWrData = '0;
  logic [4:0] modeWrData = '0;
  logic decValid, accept, perfectHit, hashHit;

  rxAddrFilter #(.HASH_BITS(HB), .NUM_ENTRIES(NE)) dut (.*);

  always #(PERIOD/2) clk = ~clk;

  int cyc = 0;
  int nVec = 0, nBad = 0;
  bit done = 0;
  always @(posedge clk) cyc++;

  // mirrors of what has been written
  logic [47:0] mEnt [NE];
  logic [NE-1:0] mOn = '0;
  logic [31:0] mHash [NW];
  logic [4:0] mMode = '0;
  initial for (int i = 0; i < NW; i++) mHash[i] = '0;

  logic [2:0] expQ [$];
  int dueQ [$];
  string tagQ [$];

  function automatic int binOf(input logic [47:0] a);
    logic [31:0] c, r;
    c = 32'hFFFFFFFF;
    for (int b = 0; b < 6; b++)
      for (int k = 0; k < 8; k++) begin
        if (c[0] ^ a[8*b+k]) c = (c >> 1) ^ 32'hEDB88320;
        else c = c >> 1;
      end
    c = ~c;
    for (int k = 0; k < 32; k++) r[31-k] = c[k];
    return int'(r >> (32 - HB));
  endfunction

  function automatic logic [2:0] model(input logic [47:0] a);
    logic grp, bc, perf, hsh, acc;
    int idx;
    grp = a[0]; bc = (a == 48'hFFFF_FFFF_FFFF); perf = 0;
    if (!grp) for (int e = 0; e < NE; e++) if (mOn[e] && mEnt[e] == a) perf = 1;
    idx = binOf(a);
    hsh = grp && !bc && mMode[2] && mHash[idx / 32][idx % 32];
    if (mMode[0] || mMode[3]) acc = 1;
    else if (bc) acc = !mMode[4];
    else if (grp) acc = mMode[1] || hsh;
    else acc = perf;
    return {acc, perf, hsh};
  endfunction

  task automatic clearAll();
    daValid = 0; entWrEn = 0; hashWrEn = 0; modeWrEn = 0;
  endtask

  task automatic lookup(input logic [47:0] a, input string tag);
    @(negedge clk); clearAll();
    daValid = 1; destAddr = a;
    expQ.push_back(model(a)); dueQ.push_back(cyc + 2); tagQ.push_back(tag);
  endtask

  task automatic wrEnt(input int i, input logic [47:0] a, input logic on);
    @(negedge clk); clearAll();
    entWrEn = 1; entWrSel = EW'(i); entWrAddr = a; entWrOn = on;
    mEnt[i] = a; mOn[i] = on;
  endtask

  task automatic wrHash(input int w, input logic [31:0] d);
    @(negedge clk); clearAll();
    hashWrEn = 1; hashWrSel = WW'(w); hashWrData = d; mHash[w] = d;
  endtask

  task automatic wrMode(input logic [4:0] m);
    @(negedge clk); clearAll();
    modeWrEn = 1; modeWrData = m; mMode = m;
  endtask

  task automatic settle();
    @(negedge clk); clearAll();
    repeat (4) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nVec++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // monitor: pops one expected item per decision pulse
  always @(negedge clk) begin
    if (rstN && decValid) begin
      if (expQ.size() == 0) check("R1 unexpected pulse", 1, 0);
      else begin
        automatic logic [2:0] e = expQ.pop_front();
        automatic int due = dueQ.pop_front();
        automatic string t = tagQ.pop_front();
        check({t, " decision"}, {29'b0, accept, perfectHit, hashHit}, {29'b0, e});
        check("R1 latency", cyc, due);
      end
    end else if (rstN) begin
      if (accept || perfectHit || hashHit) check("R1 idle outputs", {accept, perfectHit, hashHit}, 0);
    end
  end

  function automatic logic [47:0] findMc(input int word, input int avoid);
    for (int k = 0; k < 256; k++) begin
      automatic logic [47:0] a = {32'hA1B2C3D4, 8'(k), 8'h01};
      if (binOf(a) / 32 == word && binOf(a) != avoid) return a;
    end
    return 48'h0000_0000_0001;
  endfunction

  initial begin
    logic [47:0] stn, alt, off, mcLo, mcHi, mcOther;
    int bLo, bHi;
    stn = 48'h5544_3322_1100; alt = 48'h6655_4433_2210; off = 48'h0BAD_0000_0002;
    repeat (3) @(negedge clk);
    check("R11 reset outputs", {decValid, accept, perfectHit, hashHit}, 0);
    rstN = 1;
    // R11: empty tables after reset drop everything but broadcast
    lookup(stn, "R11 unicast after reset");
    lookup(findMc(0, -1), "R11 multicast after reset");
    lookup(48'hFFFF_FFFF_FFFF, "R7 broadcast default");
    settle();

    // R8 exact match table
    wrEnt(0, stn, 1); wrEnt(1, alt, 1); wrEnt(2, off, 0);
    lookup(stn, "R8 station entry");
    lookup(alt, "R8 extra entry");
    lookup(off, "R8 disabled entry");
    lookup(48'h0123_4567_89AA, "R9 unknown unicast");
    settle();

    // R9 multicast without any multicast mode
    mcLo = findMc(0, -1); mcHi = findMc(NW - 1, -1);
    bLo = binOf(mcLo); bHi = binOf(mcHi);
    mcOther = findMc(0, bLo);
    lookup(mcLo, "R9 multicast no mode");

    // R2/R3 hash lookup
    wrHash(0, 32'h1 << (bLo % 32));
    wrHash(NW - 1, 32'h1 << (bHi % 32));
    wrMode(5'b00100);
    lookup(mcLo, "R2 low word bin");
    lookup(mcHi, "R3 high word bin");
    lookup(mcOther, "R3 clear bin");
    lookup(stn, "R10 perfect flag");
    wrHash(0, ~(32'h1 << (bLo % 32)));
    lookup(mcLo, "R3 own bit clear");
    lookup(mcOther, "R3 other bits set");
    lookup(48'hFFFF_FFFF_FFFF, "R7 broadcast hash mode");
    settle();

    // R7 broadcast disable
    wrMode(5'b10100);
    lookup(48'hFFFF_FFFF_FFFF, "R7 broadcast disabled");
    lookup(stn, "R8 station with bcast off");
    // R5 pass all multicast
    wrMode(5'b00010);
    lookup(mcLo, "R5 multicast passed");
    lookup(findMc(NW - 1, bHi), "R5 multicast other bin");
    lookup(48'h0123_4567_89AA, "R5 unicast still filtered");
    // R4 promiscuous
    wrMode(5'b10001);
    lookup(48'h0123_4567_89AA, "R4 unknown unicast");
    lookup(48'hFFFF_FFFF_FFFF, "R4 broadcast disabled");
    lookup(mcOther, "R4 multicast");
    lookup(stn, "R4 station flag");
    // R6 receive all
    wrMode(5'b11000);
    lookup(off, "R6 disabled entry");
    lookup(mcOther, "R6 multicast");
    // entry disable then reuse
    wrMode(5'b00000);
    wrEnt(0, stn, 0);
    lookup(stn, "R8 station disabled");
    wrEnt(3, stn, 1);
    lookup(stn, "R8 station in entry 3");
    settle();

    check("R1 queue drained", expQ.size(), 0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      done = 1;
      nVec++; nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule